// File: doc/BRIEF.md
# Dual-Plane Pixel Source Selector

This block builds one display pixel per clock from three aligned per-pixel inputs. The inputs are an 8-bit colour index, a 32-bit true-colour word and a 32-bit control word. The top byte of the control word is a tag. When the tag carries the direct-colour code, the pixel takes its red, green and blue straight from the true-colour word. Any other tag sends the index to an external palette, and the pixel takes the colour the palette returns. A global index-only mode covers frame buffers that have only the 8-bit plane. In that mode every pixel goes to the palette, and the other two planes are not looked at.

The palette answers a fixed number of cycles after each request. True-colour pixels travel through a matching delay, so both kinds of pixel leave in the order they arrived. A column counter marks the last pixel of each active line against a programmed width. Lines may be up to 1024 pixels wide. Both the input and the output are valid/ready streams. Output backpressure is absorbed by a small credit-controlled buffer, so no pixel is dropped or repeated.

Top module: `pix_src_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `pal_req` are low and `in_ready` is high.
- R2: When `idx_only` is 0 and bits 31:24 of `in_ctrl` equal 0x03, the output colour is bits 23:0 of `in_dir` (red 23:16, green 15:8, blue 7:0). Bits 31:24 of `in_dir` have no effect.
- R3: When `idx_only` is 0 and the tag in bits 31:24 of `in_ctrl` is any value other than 0x03, the output colour is the palette response for `in_idx`.
- R4: When `idx_only` is 1, every pixel takes its palette colour, whatever `in_ctrl` and `in_dir` hold.
- R5: `pal_req` is high exactly in the cycles where a palette pixel is accepted (`in_valid` and `in_ready`), with `pal_idx` equal to `in_idx`. `pal_rgb` is sampled `LUT_LAT` cycles after the request.
- R6: `out_last` is set on the accepted pixel whose column, counted from 0 since reset or since the previous last pixel, equals `line_width` minus 1. If the column reaches 1023 first, that pixel is marked last instead. A `line_width` of 0 marks every pixel last.
- R7: Output pixels appear in input order, none lost or repeated, under any pattern of `out_ready`. While `out_valid` is high and `out_ready` is low, `out_rgb` and `out_last` hold.
- R8: With the buffer empty and `out_ready` high, a pixel accepted in cycle c appears with `out_valid` in cycle c + `LUT_LAT` + 1.
- R9: With `out_ready` held high, `in_ready` stays high, so one pixel per cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_only | input | 1 | 1 forces every pixel through the palette |
| line_width | input | 11 | Active pixels per line, 1 to 1024 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_idx | input | 8 | Colour index plane |
| in_dir | input | 32 | True-colour plane word |
| in_ctrl | input | 32 | Control plane word, tag in bits 31:24 |
| pal_req | output | 1 | Palette lookup request |
| pal_idx | output | 8 | Palette index to look up |
| pal_rgb | input | 24 | Palette colour, `LUT_LAT` cycles after request |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_rgb | output | 24 | Output colour, red in 23:16 |
| out_last | output | 1 | Last pixel of the active line |

## Verification
A misaligned delay stage would pair a true-colour pixel with a neighbour's palette answer. That shows as a wrong `out_rgb` on the first mixed stream, about `LUT_LAT` + 1 cycles after the pixel went in. A slip in the column counter shifts `out_last` by one or more pixels and is caught at the first line end. A credit count that is too loose overwrites a buffered pixel while the output is stalled. That shows as a skipped or repeated colour, seen on the next pop after backpressure is released.

// File: rtl/pss_pkg.sv
package pss_pkg;
   localparam int CLR_W = 24;

   typedef logic [CLR_W-1:0] rgb_t;

   typedef struct packed {
      logic use_dir;
      rgb_t dir_rgb;
      logic eol;
   } pss_slot_t;

   typedef struct packed {
      rgb_t rgb;
      logic eol;
   } pss_out_t;
endpackage

// File: rtl/pss_tag_decode.sv
module pss_tag_decode #(
   parameter int WORD_W     = 32,
   parameter int TAG_W      = 8,
   parameter int TAG_DIRECT = 3
) (
   input  logic                idx_only,
   input  logic [WORD_W-1:0]   ctrl_word,
   input  logic [WORD_W-1:0]   dir_word,
   output logic                use_dir,
   output pss_pkg::rgb_t       dir_rgb
);
   localparam int TAG_LSB = WORD_W - TAG_W;

   generate
      if (WORD_W < pss_pkg::CLR_W + TAG_W) begin : g_bad_width
         $error("pss_tag_decode: WORD_W too small for colour and tag");
      end
   endgenerate

   logic [TAG_W-1:0] tag;

   always_comb begin
      tag     = ctrl_word[WORD_W-1:TAG_LSB];
      use_dir = !idx_only && (tag == TAG_W'(TAG_DIRECT));
      dir_rgb = dir_word[pss_pkg::CLR_W-1:0];
   end
endmodule

// File: rtl/pss_line_count.sv
module pss_line_count #(
   parameter int MAX_W = 1024,
   parameter int CW    = $clog2(MAX_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [CW-1:0] width,
   output logic          eol
);
   generate
      if (MAX_W < 2) begin : g_bad_max
         $error("pss_line_count: MAX_W must be at least 2");
      end
   endgenerate

   logic [CW-1:0] col;
   logic [CW-1:0] col_nx;

   always_comb begin
      col_nx = col + 1'b1;
      eol    = (col_nx >= width) || (col == CW'(MAX_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
      end else if (step) begin
         col <= eol ? '0 : col_nx;
      end
   end

   a_r6_col_range: assert property (@(posedge clk) disable iff (!rst_n)
      col < CW'(MAX_W));
endmodule

// File: rtl/pss_delay_line.sv
module pss_delay_line #(
   parameter int LAT = 2,
   parameter int CW  = $clog2(LAT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  pss_pkg::pss_slot_t  in_slot,
   output logic                out_vld,
   output pss_pkg::pss_slot_t  out_slot,
   output logic [CW-1:0]       inflight
);
   generate
      if (LAT < 1) begin : g_bad_lat
         $error("pss_delay_line: LAT must be at least 1");
      end
   endgenerate

   logic               v [LAT];
   pss_pkg::pss_slot_t s [LAT];

   generate
      for (genvar i = 0; i < LAT; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) v[0] <= 1'b0;
               else        v[0] <= in_vld;
            end
            always_ff @(posedge clk) s[0] <= in_slot;
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) v[i] <= 1'b0;
               else        v[i] <= v[i-1];
            end
            always_ff @(posedge clk) s[i] <= s[i-1];
         end
      end
   endgenerate

   always_comb begin
      inflight = '0;
      for (int k = 0; k < LAT; k++) inflight = inflight + CW'(v[k]);
      out_vld  = v[LAT-1];
      out_slot = s[LAT-1];
   end
endmodule

// File: rtl/pss_out_fifo.sv
module pss_out_fifo #(
   parameter int DEPTH = 4,
   parameter int PW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  pss_pkg::pss_out_t wdata,
   input  logic              pop,
   output pss_pkg::pss_out_t rdata,
   output logic              vld,
   output logic [CW-1:0]     occ
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pss_out_fifo: DEPTH must be at least 2");
      end
   endgenerate

   pss_pkg::pss_out_t mem [DEPTH];
   logic [PW-1:0]     wp, rp;
   logic [CW-1:0]     cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_comb begin
      rdata = mem[rp];
      vld   = (cnt != '0);
      occ   = cnt;
   end

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> cnt < CW'(DEPTH));
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt != '0);
endmodule

// File: rtl/pix_src_sel.sv
module pix_src_sel #(
   parameter int IDX_W      = 8,
   parameter int WORD_W     = 32,
   parameter int TAG_W      = 8,
   parameter int TAG_DIRECT = 3,
   parameter int LUT_LAT    = 2,
   parameter int MAX_W      = 1024
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          idx_only,
   input  logic [$clog2(MAX_W+1)-1:0]    line_width,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [IDX_W-1:0]              in_idx,
   input  logic [WORD_W-1:0]             in_dir,
   input  logic [WORD_W-1:0]             in_ctrl,
   output logic                          pal_req,
   output logic [IDX_W-1:0]              pal_idx,
   input  logic [pss_pkg::CLR_W-1:0]     pal_rgb,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [pss_pkg::CLR_W-1:0]     out_rgb,
   output logic                          out_last
);
   localparam int FIFO_D = LUT_LAT + 2;
   localparam int CNT_W  = $clog2(FIFO_D + 1);
   localparam int LW_W   = $clog2(MAX_W + 1);

   generate
      if (LUT_LAT < 1) begin : g_bad_lat
         $error("pix_src_sel: LUT_LAT must be at least 1");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("pix_src_sel: IDX_W out of range");
      end
   endgenerate

   logic               accept, use_dir, eol, dl_vld, pop;
   pss_pkg::rgb_t      dir_rgb;
   pss_pkg::pss_slot_t in_slot, dl_slot;
   pss_pkg::pss_out_t  wdata, rdata;
   logic [CNT_W-1:0]   occ, inflight;

   pss_tag_decode #(.WORD_W(WORD_W), .TAG_W(TAG_W), .TAG_DIRECT(TAG_DIRECT)) u_dec (
      .idx_only (idx_only),
      .ctrl_word(in_ctrl),
      .dir_word (in_dir),
      .use_dir  (use_dir),
      .dir_rgb  (dir_rgb)
   );

   pss_line_count #(.MAX_W(MAX_W), .CW(LW_W)) u_col (
      .clk  (clk),
      .rst_n(rst_n),
      .step (accept),
      .width(line_width),
      .eol  (eol)
   );

   pss_delay_line #(.LAT(LUT_LAT), .CW(CNT_W)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (accept),
      .in_slot (in_slot),
      .out_vld (dl_vld),
      .out_slot(dl_slot),
      .inflight(inflight)
   );

   pss_out_fifo #(.DEPTH(FIFO_D), .PW($clog2(FIFO_D)), .CW(CNT_W)) u_buf (
      .clk  (clk),
      .rst_n(rst_n),
      .push (dl_vld),
      .wdata(wdata),
      .pop  (pop),
      .rdata(rdata),
      .vld  (out_valid),
      .occ  (occ)
   );

   always_comb begin
      in_ready = ({1'b0, occ} + {1'b0, inflight}) < (CNT_W + 1)'(FIFO_D);
      accept   = in_valid && in_ready;
      pal_req  = accept && !use_dir;
      pal_idx  = in_idx;
      in_slot  = '{use_dir: use_dir, dir_rgb: dir_rgb, eol: eol};
      wdata    = '{rgb: dl_slot.use_dir ? dl_slot.dir_rgb : pal_rgb, eol: dl_slot.eol};
      pop      = out_valid && out_ready;
      out_rgb  = rdata.rgb;
      out_last = rdata.eol;
   end

   a_r5_req_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> !pal_req);
   a_r4_idx_only_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      idx_only && in_valid && in_ready |-> pal_req);
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_last));
   a_r9_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, occ} + {1'b0, inflight}) <= (CNT_W + 1)'(FIFO_D));
endmodule

// File: tb/pix_src_sel_test.sv
module pix_src_sel_test;
   localparam int LAT  = 2;
   localparam int MAXW = 1024;
   localparam int WB   = $clog2(MAXW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_only = 1'b0;
   logic [WB-1:0] line_width = WB'(8);
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_idx = '0;
   logic [31:0]   in_dir = '0;
   logic [31:0]   in_ctrl = '0;
   logic          pal_req;
   logic [7:0]    pal_idx;
   logic [23:0]   pal_rgb;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [23:0]   out_rgb;
   logic          out_last;

   always #4 clk = ~clk;

   pix_src_sel #(.LUT_LAT(LAT), .MAX_W(MAXW)) uut (
      .clk(clk), .rst_n(rst_n), .idx_only(idx_only), .line_width(line_width),
      .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_dir(in_dir),
      .in_ctrl(in_ctrl), .pal_req(pal_req), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
      .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb), .out_last(out_last)
   );

   int n_chk = 0, n_fail = 0, cyc = 0, bcol = 0;
   bit lat_mode = 0, thru_mode = 0, stall_seen = 0, bp_rand = 0;
   logic [23:0] q_rgb [$];
   logic        q_last [$];
   int          q_t [$];
   int          q_kind [$];

   function automatic logic [23:0] pal_f(logic [7:0] i);
      return {i ^ 8'h5A, ~i, i + 8'd7};
   endfunction

   // palette model: answer LAT cycles after the request, garbage otherwise
   logic [23:0] pp [LAT];
   initial for (int i = 0; i < LAT; i++) pp[i] = 24'hDEAD00;
   always @(posedge clk) begin
      pp[0] <= pal_req ? pal_f(pal_idx) : 24'hBAD0BA;
      for (int i = 1; i < LAT; i++) pp[i] <= pp[i-1];
   end
   assign pal_rgb = pp[LAT-1];

   always @(negedge clk) if (bp_rand) out_ready = ($urandom % 3) != 0;

   // reference model, compared on every clock
   logic        m_dir, m_acc, m_req, m_last, e_last;
   logic [23:0] m_rgb, e_rgb;
   int          e_t, e_k;
   always @(posedge clk) if (rst_n) begin
      cyc++;
      m_dir = !idx_only && in_ctrl[31:24] == 8'h03;
      m_acc = in_valid && in_ready;
      m_req = m_acc && !m_dir;
      if (m_req || pal_req) begin
         n_chk++;
         if (pal_req !== m_req || (m_req && pal_idx !== in_idx)) begin
            n_fail++;
            $display("FAIL R5 pal_req=%b idx=%h expected req=%b idx=%h", pal_req, pal_idx, m_req, in_idx);
         end
      end
      if (out_valid && out_ready) begin
         n_chk++;
         if (q_rgb.size() == 0) begin
            n_fail++;
            $display("FAIL R7 extra output rgb=%h expected none", out_rgb);
         end else begin
            e_rgb = q_rgb.pop_front(); e_last = q_last.pop_front();
            e_t = q_t.pop_front(); e_k = q_kind.pop_front();
            if (out_last !== e_last) begin
               n_fail++;
               $display("FAIL R6 out_last=%b expected %b", out_last, e_last);
            end else if (out_rgb !== e_rgb) begin
               n_fail++;
               $display("FAIL R%0d out_rgb=%h expected %h", e_k, out_rgb, e_rgb);
            end else if (lat_mode && (cyc - e_t) != LAT + 1) begin
               n_fail++;
               $display("FAIL R8 latency=%0d expected %0d", cyc - e_t, LAT + 1);
            end
         end
      end
      if (m_acc) begin
         m_rgb  = m_dir ? in_dir[23:0] : pal_f(in_idx);
         m_last = (bcol + 1 >= int'(line_width)) || bcol == MAXW - 1;
         q_rgb.push_back(m_rgb); q_last.push_back(m_last); q_t.push_back(cyc);
         q_kind.push_back(m_dir ? 2 : (idx_only ? 4 : 3));
         bcol = m_last ? 0 : bcol + 1;
      end
   end

   task automatic send(input logic [7:0] idx, input logic [31:0] dir, input logic [31:0] ctrl);
      in_valid = 1'b1; in_idx = idx; in_dir = dir; in_ctrl = ctrl;
      while (!in_ready) begin
         if (thru_mode) stall_seen = 1;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      in_valid = 1'b0;
      for (int k = 0; k < 5000 && q_rgb.size() != 0; k++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", what);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog expired, actual hung expected done");
      finish_run();
   end

   logic [7:0] tags [7] = '{8'h03, 8'h02, 8'h04, 8'h83, 8'hFF, 8'h00, 8'h30};

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 0 && in_ready == 1 && pal_req == 0,
            $sformatf("R1 in reset valid=%b ready=%b expected 0 1", out_valid, in_ready));
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && in_ready == 1,
            $sformatf("R1 after reset valid=%b ready=%b expected 0 1", out_valid, in_ready));

      // R8: single direct pixel, top byte of direct word set (R2)
      out_ready = 1'b1; lat_mode = 1;
      send(8'h11, 32'hAB123456, 32'h03000000);
      idle(8);
      send(8'h22, 32'h00000000, 32'h02FFFFFF);
      idle(8);

      // R9: full-rate mixed stream, R2 and R3 tags
      thru_mode = 1; stall_seen = 0;
      for (int i = 0; i < 40; i++)
         send(8'(i * 7), {8'hFF, 8'(i), 8'(i + 3), 8'(i ^ 8'h3C)}, {tags[i % 7], 24'h0});
      idle(8);
      thru_mode = 0; lat_mode = 0;
      check(stall_seen == 0, $sformatf("R9 in_ready dropped=%b expected 0", stall_seen));

      // R4: index-only mode ignores the direct tag
      idx_only = 1'b1;
      for (int i = 0; i < 16; i++) send(8'(200 + i), 32'h00ABCDEF, 32'h03000000);
      idle(2);
      idx_only = 1'b0;
      drain();

      // R6: width 1, then full width, then an over-range width
      line_width = WB'(1);
      for (int i = 0; i < 6; i++) send(8'(i), 32'h0, 32'h0);
      drain();
      line_width = WB'(1024);
      for (int i = 0; i < 1030; i++) send(8'(i), {8'h0, 24'(i * 3)}, {(i % 2) ? 8'h03 : 8'h01, 24'h0});
      drain();
      line_width = WB'(1025);
      for (int i = 0; i < 1030; i++) send(8'(i), 32'h0, 32'h0);
      drain();

      // R7: random backpressure, bubbles and mode changes
      line_width = WB'(7);
      bp_rand = 1;
      for (int i = 0; i < 400; i++) begin
         idx_only = ($urandom % 5) == 0;
         send(8'($urandom), $urandom, {(($urandom % 2) != 0) ? 8'h03 : 8'($urandom), 24'($urandom)});
         if (($urandom % 4) == 0) idle(1 + $urandom % 3);
      end
      idx_only = 1'b0;
      in_valid = 1'b0;
      repeat (20) @(negedge clk);
      bp_rand = 0; out_ready = 1'b1;
      drain();
      check(q_rgb.size() == 0, $sformatf("R7 pixels missing=%0d expected 0", q_rgb.size()));
      check(out_valid == 0, $sformatf("R7 out_valid=%b after drain expected 0", out_valid));
      finish_run();
   end
endmodule